// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block resolves translation misses for a 32-bit segmented address space. It takes one missing effective address at a time. The top four address bits pick one of sixteen segment descriptors. The 24-bit segment identifier held in that descriptor stands in for those four bits, which gives a 52-bit virtual address. In the cycle the miss is accepted, a bank of block-translation windows is compared against the address. If any window covers the address, the block answers directly from the window and starts no table search.

When no window hits, the block hashes the segment identifier with the page index and fetches a group of eight table entries from memory, one read at a time, through a simple request/valid port. If the primary group holds no match, it repeats the scan on a secondary group whose index is the bitwise complement of the primary hash. When both groups fail, it reports a fault so that the operating system can take over. On a hit it returns the real page number joined with the 4 KB page offset. It also returns the no-execute flag of the selected segment.

Top module: `hpt_search_engine`

## Requirements
- R1: While and after reset, until a miss is accepted, `res_valid`, `mem_req` and `busy` are 0.
- R2: `miss_ea[31:28]` selects segment descriptor n, whose identifier is `seg_vsid[24n+23:24n]` and whose no-execute flag is `seg_nx[n]`; the page index is `miss_ea[27:12]`.
- R3: Window k hits when `bat_valid[k]` is set and `(miss_ea[31:17] ^ epi_k) & ~{4'b0,msk_k}` is zero. A hit gives `res_pa = {(rpi_k & ~m) | (miss_ea[31:17] & m), miss_ea[16:0]}` with `res_nx=0` and `res_fault=0`. The result appears one cycle after acceptance, and no memory read is made.
- R4: When several windows hit, the lowest-numbered one supplies the result.
- R5: The primary hash is `seg_id[18:0] ^ {3'b0, page_index}`. The read address of slot s in pass p is `{base[31:25], base[24:16] | (h[18:10] & mask), h[9:0], s[2:0], 3'b000}`, where h is the hash of pass p.
- R6: A 64-bit entry is {valid[63], hash_id[62], seg_id[61:38], api[37:32], unused[31:20], rpn[19:0]}. It matches when valid=1, hash_id equals the pass number (0 primary, 1 secondary), seg_id equals the segment identifier, and api equals `miss_ea[27:22]`.
- R7: Slots are read in the order 0 to 7, with at most one read outstanding at any time. The scan stops at the first matching slot.
- R8: After eight primary reads with no match, the same scan is repeated with the secondary hash `~h_primary`.
- R9: A table hit returns `res_pa = {rpn, miss_ea[11:0]}` with `res_nx = seg_nx[n]`.
- R10: After sixteen reads with no match, the block reports `res_fault=1` with `res_pa=0` and `res_nx=0`.
- R11: `res_valid` is a one-cycle pulse, and `busy` is 0 in that cycle.
- R12: A `miss_valid` that arrives while `busy` is 1 is ignored. It neither changes the current result nor produces a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request, taken when not busy |
| miss_ea | input | 32 | Effective address that missed |
| busy | output | 1 | Search in progress |
| seg_vsid | input | 384 | Sixteen 24-bit segment identifiers |
| seg_nx | input | 16 | Per-segment no-execute flags |
| bat_valid | input | 4 | Window enables |
| bat_epi | input | 60 | Window effective base, 15 bits each |
| bat_msk | input | 44 | Window size masks, 11 bits each |
| bat_rpi | input | 60 | Window real base, 15 bits each |
| htab_base | input | 16 | Table base, address bits 31:16 |
| htab_mask | input | 9 | Table size mask on hash bits 18:10 |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | No translation found |
| res_pa | output | 32 | Physical address |
| res_nx | output | 1 | No-execute flag |

## Verification
The bench plants the matching entry in slot 0, slot 7 and the secondary group. It also plants decoys that differ only in hash_id, valid, api or segment identifier. A block that ignored the hash_id bit or checked the wrong pass would return a decoy early, which shows up as a short read count. A missing complement on the second pass reads the wrong group and ends in a fault. Overlapping windows and windows with nonzero size masks are exercised: a wrong priority or a wrong merge of offset bits gives a wrong physical address, and letting a window hit still start a search gives a nonzero read count. A second miss sent mid-search would, if it were taken, corrupt the result or produce a second pulse.

// File: rtl/hpt_pkg.sv
// Shared types for the hashed page table search engine.
// Assumes 32-bit effective addresses, 4 KB pages and 64-bit table entries.
package hpt_pkg;
    localparam int EA_W    = 32;
    localparam int VSID_W  = 24;
    localparam int HASH_W  = 19;
    localparam int PIDX_W  = 16;
    localparam int API_W   = 6;
    localparam int RPN_W   = 20;
    localparam int BLK_W   = 15;   // window base, address bits 31:17
    localparam int BMSK_W  = 11;   // window size mask over address bits 27:17
    localparam int SLOTS   = 8;
    localparam int SLOT_W  = $clog2(SLOTS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } hpt_state_t;

    typedef struct packed {
        logic              valid;
        logic              hid;
        logic [VSID_W-1:0] vsid;
        logic [API_W-1:0]  api;
        logic [11:0]       unused;
        logic [RPN_W-1:0]  rpn;
    } hpt_entry_t;
endpackage

// File: rtl/hpt_bat_match.sv
// Parallel block-window compare. Each window covers 128 KB times a power of
// two, up to 256 MB. The lowest-numbered window that hits supplies the result.
// Purely combinational; the caller registers the result.
module hpt_bat_match
    import hpt_pkg::*;
#(
    parameter int NBAT = 4
) (
    input  logic [EA_W-1:0]        ea,
    input  logic [NBAT-1:0]        win_valid,
    input  logic [NBAT*BLK_W-1:0]  win_epi,
    input  logic [NBAT*BMSK_W-1:0] win_msk,
    input  logic [NBAT*BLK_W-1:0]  win_rpi,
    output logic                   hit,
    output logic [EA_W-1:0]        pa
);
    localparam int PAD_W = BLK_W - BMSK_W;

    logic [NBAT-1:0]  hit_vec;
    logic [EA_W-1:0]  pa_vec [NBAT];

    // One comparator and one address merge per window.
    for (genvar k = 0; k < NBAT; k++) begin : g_win
        logic [BLK_W-1:0] m;
        assign m = {{PAD_W{1'b0}}, win_msk[k*BMSK_W +: BMSK_W]};
        assign hit_vec[k] = win_valid[k] &&
            (((ea[EA_W-1:17] ^ win_epi[k*BLK_W +: BLK_W]) & ~m) == '0);
        assign pa_vec[k] = {(win_rpi[k*BLK_W +: BLK_W] & ~m) | (ea[EA_W-1:17] & m),
                            ea[16:0]};
    end

    // Priority select: the lowest index wins.
    always_comb begin
        hit = |hit_vec;
        pa  = '0;
        for (int k = NBAT - 1; k >= 0; k--) begin
            if (hit_vec[k]) pa = pa_vec[k];
        end
    end
endmodule

// File: rtl/hpt_group_addr.sv
// Forms the hash for one pass and the byte address of one slot in its group.
// Pass 0 uses the primary hash; pass 1 uses its complement.
module hpt_group_addr
    import hpt_pkg::*;
(
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic              pass,
    input  logic [SLOT_W-1:0] slot,
    input  logic [15:0]       tbl_base,
    input  logic [8:0]        tbl_mask,
    output logic [EA_W-1:0]   addr
);
    logic [HASH_W-1:0] h_pri;
    logic [HASH_W-1:0] h;

    // Hash selection for the current pass.
    always_comb begin
        h_pri = vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
        h     = pass ? ~h_pri : h_pri;
        addr  = {tbl_base[15:9], tbl_base[8:0] | (h[18:10] & tbl_mask),
                 h[9:0], slot, 3'b000};
    end
endmodule

// File: rtl/hpt_entry_cmp.sv
// Decodes one table entry and decides whether it translates the pending page.
module hpt_entry_cmp
    import hpt_pkg::*;
(
    input  logic [63:0]       rdata,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              pass,
    output logic              match,
    output logic [RPN_W-1:0]  rpn
);
    hpt_entry_t ent;

    // Field compare of a single entry.
    always_comb begin
        ent   = hpt_entry_t'(rdata);
        match = ent.valid && (ent.hid == pass) && (ent.vsid == vsid) && (ent.api == api);
        rpn   = ent.rpn;
    end
endmodule

// File: rtl/hpt_search_engine.sv
// Translation-miss handler: segment expansion, block-window check and a
// two-pass scan of eight-entry hash groups. Assumes the memory port accepts
// every mem_req and answers each with exactly one mem_rvalid, in order.
module hpt_search_engine
    import hpt_pkg::*;
#(
    parameter int NBAT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   miss_valid,
    input  logic [31:0]            miss_ea,
    output logic                   busy,
    input  logic [16*24-1:0]       seg_vsid,
    input  logic [15:0]            seg_nx,
    input  logic [NBAT-1:0]        bat_valid,
    input  logic [NBAT*15-1:0]     bat_epi,
    input  logic [NBAT*11-1:0]     bat_msk,
    input  logic [NBAT*15-1:0]     bat_rpi,
    input  logic [15:0]            htab_base,
    input  logic [8:0]             htab_mask,
    output logic                   mem_req,
    output logic [31:0]            mem_addr,
    input  logic                   mem_rvalid,
    input  logic [63:0]            mem_rdata,
    output logic                   res_valid,
    output logic                   res_fault,
    output logic [31:0]            res_pa,
    output logic                   res_nx
);
    hpt_state_t        state;
    logic [EA_W-1:0]   ea_q;
    logic [VSID_W-1:0] vsid_q;
    logic              nx_q;
    logic              pass_q;
    logic [SLOT_W-1:0] slot_q;

    logic              bat_hit;
    logic [EA_W-1:0]   bat_pa;
    logic              ent_match;
    logic [RPN_W-1:0]  ent_rpn;
    logic [3:0]        seg_sel;

    assign seg_sel = miss_ea[31:28];

    hpt_bat_match #(.NBAT(NBAT)) i_bat (
        .ea(miss_ea), .win_valid(bat_valid), .win_epi(bat_epi),
        .win_msk(bat_msk), .win_rpi(bat_rpi), .hit(bat_hit), .pa(bat_pa)
    );

    hpt_group_addr i_gaddr (
        .vsid(vsid_q), .pidx(ea_q[27:12]), .pass(pass_q), .slot(slot_q),
        .tbl_base(htab_base), .tbl_mask(htab_mask), .addr(mem_addr)
    );

    hpt_entry_cmp i_cmp (
        .rdata(mem_rdata), .vsid(vsid_q), .api(ea_q[27:22]), .pass(pass_q),
        .match(ent_match), .rpn(ent_rpn)
    );

    // Status and request strobes decoded from the state.
    assign busy    = (state != ST_IDLE);
    assign mem_req = (state == ST_REQ);

    // Search sequencer and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ea_q      <= '0;
            vsid_q    <= '0;
            nx_q      <= 1'b0;
            pass_q    <= 1'b0;
            slot_q    <= '0;
            res_valid <= 1'b0;
            res_fault <= 1'b0;
            res_pa    <= '0;
            res_nx    <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (miss_valid) begin
                        ea_q   <= miss_ea;
                        vsid_q <= seg_vsid[seg_sel*VSID_W +: VSID_W];
                        nx_q   <= seg_nx[seg_sel];
                        pass_q <= 1'b0;
                        slot_q <= '0;
                        if (bat_hit) begin
                            res_valid <= 1'b1;
                            res_fault <= 1'b0;
                            res_pa    <= bat_pa;
                            res_nx    <= 1'b0;
                        end else begin
                            state <= ST_REQ;
                        end
                    end
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (ent_match) begin
                            res_valid <= 1'b1;
                            res_fault <= 1'b0;
                            res_pa    <= {ent_rpn, ea_q[11:0]};
                            res_nx    <= nx_q;
                            state     <= ST_IDLE;
                        end else if (slot_q == SLOT_W'(SLOTS - 1)) begin
                            if (pass_q) begin
                                res_valid <= 1'b1;
                                res_fault <= 1'b1;
                                res_pa    <= '0;
                                res_nx    <= 1'b0;
                                state     <= ST_IDLE;
                            end else begin
                                pass_q <= 1'b1;
                                slot_q <= '0;
                                state  <= ST_REQ;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                            state  <= ST_REQ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hpt_search_checker.sv
// Protocol and result-shape properties for hpt_search_engine, bound to it below.
module hpt_search_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        miss_valid,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic        res_valid,
    input logic        res_fault,
    input logic [31:0] res_pa,
    input logic        res_nx
);
    logic       outstanding;
    logic [4:0] reads;

    // Tracks whether a read is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)          outstanding <= 1'b0;
        else if (mem_req)    outstanding <= 1'b1;
        else if (mem_rvalid) outstanding <= 1'b0;
    end

    // Counts reads returned during one search.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) reads <= '0;
        else if (mem_rvalid) reads <= reads + 5'd1;
    end

    assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding && !mem_rvalid) |-> !mem_req);

    assert_read_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reads <= 5'd16);

    assert_accept_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_valid) |=> (res_valid || busy));

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_idle_on_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!busy && !mem_req));

    assert_fault_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_pa == 32'd0 && !res_nx));

    assert_req_in_search_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind hpt_search_engine hpt_search_checker i_chk (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .busy(busy),
    .mem_req(mem_req), .mem_rvalid(mem_rvalid), .res_valid(res_valid),
    .res_fault(res_fault), .res_pa(res_pa), .res_nx(res_nx)
);

// File: tb/test_hpt_search_engine.sv
// Self-checking bench: random segment/table setups plus directed corner cases.
module test_hpt_search_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_ea = '0;
    logic        busy;
    logic [383:0] seg_vsid = '0;
    logic [15:0] seg_nx = '0;
    logic [3:0]  bat_valid = '0;
    logic [59:0] bat_epi = '0;
    logic [43:0] bat_msk = '0;
    logic [59:0] bat_rpi = '0;
    logic [15:0] htab_base = 16'h4000;
    logic [8:0]  htab_mask = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        res_valid, res_fault, res_nx;
    logic [31:0] res_pa;

    int total = 0;
    int bad = 0;
    int nreq = 0;
    int cycles = 0;
    int lat_cnt = 0;
    logic [31:0] addr_q = '0;
    logic [63:0] tbl [logic [31:0]];

    hpt_search_engine i_hpt_search_engine (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ea(miss_ea),
        .busy(busy), .seg_vsid(seg_vsid), .seg_nx(seg_nx), .bat_valid(bat_valid),
        .bat_epi(bat_epi), .bat_msk(bat_msk), .bat_rpi(bat_rpi),
        .htab_base(htab_base), .htab_mask(htab_mask), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .res_valid(res_valid), .res_fault(res_fault), .res_pa(res_pa), .res_nx(res_nx)
    );

    always #2 clk = ~clk;

    // Memory model: two-cycle read latency, unplanted words read as zero.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= tbl.exists(addr_q) ? tbl[addr_q] : 64'd0;
            end
        end
        if (mem_req) begin
            addr_q  <= mem_addr;
            lat_cnt <= 2;
            nreq    <= nreq + 1;
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] hash_of(input logic [23:0] v, input logic [15:0] p,
                                            input logic pass);
        logic [18:0] h;
        h = v[18:0] ^ {3'b000, p};
        return pass ? ~h : h;
    endfunction

    function automatic logic [31:0] slot_addr(input logic [23:0] v, input logic [15:0] p,
                                              input logic pass, input int s);
        logic [18:0] h;
        h = hash_of(v, p, pass);
        return {htab_base[15:9], htab_base[8:0] | (h[18:10] & htab_mask), h[9:0],
                3'(s), 3'b000};
    endfunction

    function automatic logic [63:0] make_ent(input logic vld, input logic hid,
        input logic [23:0] v, input logic [5:0] api, input logic [19:0] rpn);
        return {vld, hid, v, api, 12'h000, rpn};
    endfunction

    // Reference model: returns {fault, nx, pa}; nreads gives the read count.
    function automatic logic [33:0] model(input logic [31:0] ea, output int nreads);
        logic [23:0] v;
        logic [63:0] e;
        logic [14:0] m;
        v = seg_vsid[ea[31:28]*24 +: 24];
        nreads = 0;
        for (int k = 0; k < 4; k++) begin
            m = {4'b0, bat_msk[k*11 +: 11]};
            if (bat_valid[k] && (((ea[31:17] ^ bat_epi[k*15 +: 15]) & ~m) == 15'd0))
                return {1'b0, 1'b0, (bat_rpi[k*15 +: 15] & ~m) | (ea[31:17] & m), ea[16:0]};
        end
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                logic [31:0] a;
                a = slot_addr(v, ea[27:12], p[0], s);
                e = tbl.exists(a) ? tbl[a] : 64'd0;
                nreads++;
                if (e[63] && e[62] == p[0] && e[61:38] == v && e[37:32] == ea[27:22])
                    return {1'b0, seg_nx[ea[31:28]], e[19:0], ea[11:0]};
            end
        end
        return {1'b1, 1'b0, 32'd0};
    endfunction

    // Issues one miss and waits for the result; returns cycles after acceptance.
    task automatic run_miss(input logic [31:0] ea, output int lat, output int reads);
        int n0;
        @(negedge clk);
        n0 = nreq;
        miss_valid = 1'b1;
        miss_ea = ea;
        @(negedge clk);
        miss_valid = 1'b0;
        lat = 0;
        while (!res_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        reads = nreq - n0;
    endtask

    task automatic check_miss(input string req, input logic [31:0] ea);
        int lat, reads, exp_reads;
        logic [33:0] exp;
        exp = model(ea, exp_reads);
        run_miss(ea, lat, reads);
        check({req, " result pulse"}, res_valid, 1'b1);
        check({req, " fault"}, res_fault, exp[33]);
        check({req, " nx"}, res_nx, exp[32]);
        check({req, " pa"}, res_pa, exp[31:0]);
        check({req, " reads"}, reads, exp_reads);
        check({req, " idle"}, busy, 1'b0);
    endtask

    task automatic random_segs();
        for (int i = 0; i < 16; i++) seg_vsid[i*24 +: 24] = 24'($urandom);
        seg_nx = 16'($urandom);
    endtask

    task automatic plant(input logic [31:0] ea, input int mode);
        logic [23:0] v;
        logic [5:0]  api;
        int s;
        v = seg_vsid[ea[31:28]*24 +: 24];
        api = ea[27:22];
        s = $urandom_range(0, 7);
        // Decoys that fail exactly one match condition.
        tbl[slot_addr(v, ea[27:12], 1'b0, (s + 1) % 8)] = make_ent(1'b1, 1'b1, v, api, 20'($urandom));
        tbl[slot_addr(v, ea[27:12], 1'b0, (s + 2) % 8)] = make_ent(1'b0, 1'b0, v, api, 20'($urandom));
        tbl[slot_addr(v, ea[27:12], 1'b1, (s + 3) % 8)] = make_ent(1'b1, 1'b1, v, api ^ 6'd1, 20'($urandom));
        tbl[slot_addr(v, ea[27:12], 1'b1, (s + 4) % 8)] = make_ent(1'b1, 1'b0, v, api, 20'($urandom));
        tbl[slot_addr(v, ea[27:12], 1'b0, (s + 5) % 8)] = make_ent(1'b1, 1'b0, v ^ 24'h800000, api, 20'($urandom));
        if (mode == 0)
            tbl[slot_addr(v, ea[27:12], 1'b0, s)] = make_ent(1'b1, 1'b0, v, api, 20'($urandom));
        else if (mode == 1)
            tbl[slot_addr(v, ea[27:12], 1'b1, s)] = make_ent(1'b1, 1'b1, v, api, 20'($urandom));
    endtask

    initial begin
        void'($urandom(32'd1234));
        random_segs();
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 res_valid in reset", res_valid, 1'b0);
        check("R1 mem_req in reset", mem_req, 1'b0);
        check("R1 busy in reset", busy, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 busy after reset", busy, 1'b0);
        check("R1 res_valid after reset", res_valid, 1'b0);

        // R7 R9: match in slot 0 and slot 7 of the primary group.
        begin
            logic [31:0] ea;
            logic [23:0] v;
            ea = 32'h3ABC_D123;
            v = seg_vsid[3*24 +: 24];
            tbl.delete();
            tbl[slot_addr(v, ea[27:12], 1'b0, 0)] = make_ent(1'b1, 1'b0, v, ea[27:22], 20'hABCDE);
            check_miss("R7 R9 slot0", ea);
            tbl.delete();
            tbl[slot_addr(v, ea[27:12], 1'b0, 7)] = make_ent(1'b1, 1'b0, v, ea[27:22], 20'h12345);
            check_miss("R7 R9 slot7", ea);
            // R8: only the secondary group holds the page.
            tbl.delete();
            tbl[slot_addr(v, ea[27:12], 1'b1, 2)] = make_ent(1'b1, 1'b1, v, ea[27:22], 20'h0F0F0);
            check_miss("R8 secondary", ea);
            // R10: empty table.
            tbl.delete();
            check_miss("R10 trap", ea);
            // R6: right entry but wrong hash_id in secondary group.
            tbl[slot_addr(v, ea[27:12], 1'b1, 0)] = make_ent(1'b1, 1'b0, v, ea[27:22], 20'h11111);
            check_miss("R6 hid mismatch", ea);
        end

        // R3 R4: overlapping windows, lower index wins.
        begin
            int lat, reads;
            tbl.delete();
            bat_valid = 4'b0110;
            bat_epi[1*15 +: 15] = 15'h1230;  bat_msk[1*11 +: 11] = 11'h00F;
            bat_rpi[1*15 +: 15] = 15'h5550;
            bat_epi[2*15 +: 15] = 15'h1200;  bat_msk[2*11 +: 11] = 11'h0FF;
            bat_rpi[2*15 +: 15] = 15'h7700;
            check_miss("R4 priority", {15'h1235, 17'h1ABCD});
            run_miss({15'h1245, 17'h00011}, lat, reads);
            check("R3 latency", lat, 0);
            check("R3 no reads", reads, 0);
            check("R3 merged pa", res_pa, {15'h7745, 17'h00011});
            bat_valid = '0;
        end

        // R12: second miss during search is ignored.
        begin
            logic [31:0] ea;
            logic [23:0] v;
            int n0, pulses;
            logic [33:0] exp;
            int er;
            ea = 32'h5123_4567;
            v = seg_vsid[5*24 +: 24];
            tbl.delete();
            tbl[slot_addr(v, ea[27:12], 1'b1, 3)] = make_ent(1'b1, 1'b1, v, ea[27:22], 20'h9A9A9);
            exp = model(ea, er);
            @(negedge clk);
            n0 = nreq;
            miss_valid = 1'b1; miss_ea = ea;
            @(negedge clk);
            miss_valid = 1'b0;
            repeat (5) @(negedge clk);
            miss_valid = 1'b1; miss_ea = 32'h6000_0000;
            @(negedge clk);
            miss_valid = 1'b0;
            pulses = 0;
            for (int c = 0; c < 120; c++) begin
                if (res_valid) begin
                    pulses++;
                    check("R12 first result kept", res_pa, exp[31:0]);
                end
                @(negedge clk);
            end
            check("R12 single result", pulses, 1);
            check("R12 reads", nreq - n0, er);
        end

        // R2 R5 R6 R9 R10: random configurations with decoys.
        for (int t = 0; t < 150; t++) begin
            logic [31:0] ea;
            int mode;
            random_segs();
            htab_base = 16'($urandom);
            htab_mask = 9'($urandom);
            tbl.delete();
            ea = $urandom;
            mode = $urandom_range(0, 3);
            if (mode == 3) begin
                int k;
                k = $urandom_range(0, 3);
                bat_valid = '0;
                bat_valid[k] = 1'b1;
                bat_msk[k*11 +: 11] = 11'($urandom);
                bat_epi[k*15 +: 15] = ea[31:17] ^ (15'($urandom) & {4'b0, bat_msk[k*11 +: 11]});
                bat_rpi[k*15 +: 15] = 15'($urandom);
                check_miss("R3 random window", ea);
                bat_valid = '0;
            end else begin
                plant(ea, mode);
                check_miss("R2 R5 R6 R9 R10 random", ea);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule